// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator-based processor. It combines an accumulator-side operand and a second operand (from memory, an immediate or another register), chosen by a four-bit operation code. The result, a write-back qualifier and the next N, V, Z and C values are purely combinational. Each of those four flags carries its own update enable, because every operation touches only its own subset of flags.

Binary add and subtract with carry follow two's-complement rules. When the decimal input is high, add and subtract instead work digit by digit on packed BCD operands. The logic operations, shifts and rotates, increment and decrement work on the second operand. The compare, bit-test and bit test-and-modify operations produce only the flags their instruction needs. The status flags live in a registered byte. An execute strobe commits the enabled flags, and a load strobe replaces the whole byte, for example when flags are restored from the stack.

Top module: `alu8_status`

## Requirements
- R1: The status byte packs, from bit 7 down to bit 0, N, V, an unused bit, B, D, I, Z, C. The unused bit always reads 0, and synchronous reset sets the byte to 0x04 (only I set).
- R2: With ld_en high, the next clock loads status from ld_val, with bit 5 forced to 0. The load takes precedence over exec.
- R3: With exec high and ld_en low, each of N, V, Z, C whose update enable is high takes its next value at the clock edge, and every other bit holds. With both strobes low, status holds.
- R4: PASS (op 0) gives opb, ORA (1) gives opa|opb, AND (2) gives opa&opb, EOR (3) gives opa^opb, INC (12) gives opb+1 and DEC (13) gives opb-1. These update only N and Z, with N equal to result bit 7 and Z equal to (result==0). Every operation except CMP and BIT raises res_wr.
- R5: ASL (8) and ROL (10) shift opb left and put old bit 7 in C. ROR (11) shifts right and puts old bit 0 in C. ROL fills bit 0 with carry_in, and ROR fills bit 7 with carry_in. N, Z and C update.
- R6: LSR (9) shifts opb right, fills bit 7 with 0, puts old bit 0 in C and always gives N=0. N, Z and C update.
- R7: With dec_in low, ADC (4) gives opa+opb+carry_in and SBC (5) gives opa+~opb+carry_in, so carry_in=1 means no borrow. C is the carry out of bit 7. V is set when both added operands share a sign that differs from the result's sign. N, V, Z and C all update.
- R8: With dec_in high and BCD operands, ADC gives (A+B+C) mod 100 with C set when the sum reaches 100. SBC gives (A-B-1+C) mod 100 with C set when no borrow occurs. N and Z come from the BCD result, and V follows the binary rule of R7.
- R9: CMP (6) drives result = opa-opb, N = bit 7 of that difference, Z = (opa==opb) and C = (opa>=opb). It updates only N, Z and C, and res_wr is low.
- R10: BIT (7) sets Z = ((opa&opb)==0), N = opb bit 7 and V = opb bit 6, and res_wr is low. With imm_bit high, only Z updates, and with imm_bit low, N, V and Z update.
- R11: TSB (14) gives opb|opa and TRB (15) gives opb&~opa. Only Z updates, with Z = ((opa&opb)==0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 4 | Operation code |
| opa | input | 8 | Accumulator-side operand |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| dec_in | input | 1 | Current decimal-mode flag |
| imm_bit | input | 1 | Bit test is in immediate form |
| exec | input | 1 | Commit enabled flags to status |
| ld_en | input | 1 | Load the whole status byte |
| ld_val | input | 8 | Value for a status load |
| result | output | 8 | Operation result |
| res_wr | output | 1 | Result is meant for write-back |
| n_nxt | output | 1 | Next N value |
| v_nxt | output | 1 | Next V value |
| z_nxt | output | 1 | Next Z value |
| c_nxt | output | 1 | Next C value |
| n_upd | output | 1 | N update enable |
| v_upd | output | 1 | V update enable |
| z_upd | output | 1 | Z update enable |
| c_upd | output | 1 | C update enable |
| status | output | 8 | Registered status byte |

## Verification
The checker assumes that ld_en and exec are held low while reset is active. It also assumes that op always carries one of the sixteen defined codes, which holds by construction because the code is four bits wide. The decimal-mode result is only defined for operands whose nibbles are 0 to 9, so the decimal sweep walks every valid pair of BCD bytes and never feeds a hex digit. The binary sweeps cover every value of opa against a spread of opb values, including 0x00 and 0xFF.

// File: rtl/alu8_pkg.sv
// Shared definitions for the 8-bit ALU: operation codes, status bit
// positions and the reset value of the status byte.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ORA  = 4'd1,
        OP_AND  = 4'd2,
        OP_EOR  = 4'd3,
        OP_ADC  = 4'd4,
        OP_SBC  = 4'd5,
        OP_CMP  = 4'd6,
        OP_BIT  = 4'd7,
        OP_ASL  = 4'd8,
        OP_LSR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_ROR  = 4'd11,
        OP_INC  = 4'd12,
        OP_DEC  = 4'd13,
        OP_TSB  = 4'd14,
        OP_TRB  = 4'd15
    } alu_op_e;

    localparam int FLAG_N = 7;
    localparam int FLAG_V = 6;
    localparam int FLAG_U = 5;
    localparam int FLAG_B = 4;
    localparam int FLAG_D = 3;
    localparam int FLAG_I = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

    localparam logic [7:0] STATUS_RESET = 8'h04;
    localparam logic [7:0] STATUS_MASK  = 8'hDF;
endpackage

// File: rtl/alu8_adder.sv
// Add/subtract unit with carry, in binary or packed-BCD form.
// Assumes W is a multiple of 4. BCD results are defined only for operands
// whose digits are 0..9. V always follows the binary sum.
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         dec,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         vout
);
    localparam int ND = W / 4;

    logic [W-1:0] b_eff;
    logic [W:0]   bin_sum;
    logic [W-1:0] dec_sum;
    logic [ND:0]  dcy;

    // Binary path: subtract is add of the inverted operand.
    always_comb begin
        b_eff   = sub ? ~b : b;
        bin_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        vout    = (a[W-1] == b_eff[W-1]) && (bin_sum[W-1] != a[W-1]);
    end

    assign dcy[0] = cin;

    // Decimal path: one adjusted digit per nibble, carry rippling upward.
    for (genvar i = 0; i < ND; i++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] adj;
        logic       fix;

        // Per-digit raw sum or difference and its +6/-6 correction.
        always_comb begin
            if (sub) begin
                raw = {1'b0, a[4*i +: 4]} - {1'b0, b[4*i +: 4]} - {4'b0, ~dcy[i]};
                fix = raw[4];
                adj = fix ? raw - 5'd6 : raw;
            end else begin
                raw = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, dcy[i]};
                fix = (raw > 5'd9);
                adj = fix ? raw + 5'd6 : raw;
            end
        end

        assign dec_sum[4*i +: 4] = adj[3:0];
        assign dcy[i+1]          = sub ? ~fix : fix;
    end

    // Select the binary or decimal view.
    always_comb begin
        sum  = dec ? dec_sum : bin_sum[W-1:0];
        cout = dec ? dcy[ND] : bin_sum[W];
    end
endmodule

// File: rtl/alu8_logic.sv
// Non-adder operations: logic, shifts/rotates, increment/decrement,
// compare, bit test and test-and-modify. Purely combinational.
// For the adder operations it returns zero, which the top ignores.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] diff;

    // Compare difference with an extra bit for the borrow.
    assign diff = {1'b0, a} - {1'b0, b};

    // Result and shifted-out bit for each operation.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            OP_PASS: res = b;
            OP_ORA:  res = a | b;
            OP_AND:  res = a & b;
            OP_EOR:  res = a ^ b;
            OP_ASL:  begin res = {b[W-2:0], 1'b0}; cout = b[W-1]; end
            OP_LSR:  begin res = {1'b0, b[W-1:1]}; cout = b[0];   end
            OP_ROL:  begin res = {b[W-2:0], cin};  cout = b[W-1]; end
            OP_ROR:  begin res = {cin, b[W-1:1]};  cout = b[0];   end
            OP_INC:  res = b + 1'b1;
            OP_DEC:  res = b - 1'b1;
            OP_CMP:  begin res = diff[W-1:0]; cout = ~diff[W]; end
            OP_BIT:  res = a & b;
            OP_TSB:  res = b | a;
            OP_TRB:  res = b & ~a;
            default: begin res = '0; cout = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
// Registered status byte. A load replaces every stored bit. An execute
// commits N, V, Z, C where their enables are set. Bit 5 is never stored.
// upd/nxt index order: 0=C, 1=Z, 2=V, 3=N.
module alu8_flagreg
    import alu8_pkg::*;
#(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec,
    input  logic          ld_en,
    input  logic [7:0]    ld_val,
    input  logic [NF-1:0] upd,
    input  logic [NF-1:0] nxt,
    output logic [7:0]    status
);
    localparam int FPOS [NF] = '{FLAG_C, FLAG_Z, FLAG_V, FLAG_N};

    logic [7:0] upd_bits;
    logic [7:0] nxt_bits;

    // Scatter the per-flag enables and values onto their byte positions.
    always_comb begin
        upd_bits = '0;
        nxt_bits = '0;
        for (int k = 0; k < NF; k++) begin
            upd_bits[FPOS[k]] = upd[k];
            nxt_bits[FPOS[k]] = nxt[k];
        end
    end

    // Status register with load priority over execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= STATUS_RESET;
        end else if (ld_en) begin
            status <= ld_val & STATUS_MASK;
        end else if (exec) begin
            status <= ((status & ~upd_bits) | (nxt_bits & upd_bits)) & STATUS_MASK;
        end
    end
endmodule

// File: rtl/alu8_status.sv
// Top of the 8-bit ALU: picks the adder or the logic unit, forms the next
// flags and their enables per operation, and holds the status byte.
// Assumes the caller feeds carry_in/dec_in from the flags it wants applied.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         carry_in,
    input  logic         dec_in,
    input  logic         imm_bit,
    input  logic         exec,
    input  logic         ld_en,
    input  logic [7:0]   ld_val,
    output logic [W-1:0] result,
    output logic         res_wr,
    output logic         n_nxt,
    output logic         v_nxt,
    output logic         z_nxt,
    output logic         c_nxt,
    output logic         n_upd,
    output logic         v_upd,
    output logic         z_upd,
    output logic         c_upd,
    output logic [7:0]   status
);
    alu_op_e      op_e;
    logic [W-1:0] add_sum;
    logic         add_c;
    logic         add_v;
    logic [W-1:0] lg_res;
    logic         lg_c;
    logic         is_add;

    assign op_e   = alu_op_e'(op);
    assign is_add = (op_e == OP_ADC) || (op_e == OP_SBC);

    alu8_adder #(.W(W)) u_add (
        .a    (opa),
        .b    (opb),
        .cin  (carry_in),
        .sub  (op_e == OP_SBC),
        .dec  (dec_in),
        .sum  (add_sum),
        .cout (add_c),
        .vout (add_v)
    );

    alu8_logic #(.W(W)) u_lg (
        .op   (op_e),
        .a    (opa),
        .b    (opb),
        .cin  (carry_in),
        .res  (lg_res),
        .cout (lg_c)
    );

    // Result mux, next flag values and per-operation flag enables.
    always_comb begin
        result = is_add ? add_sum : lg_res;
        res_wr = !((op_e == OP_CMP) || (op_e == OP_BIT));
        n_nxt  = result[W-1];
        v_nxt  = add_v;
        z_nxt  = (result == '0);
        c_nxt  = is_add ? add_c : lg_c;
        n_upd  = 1'b1;
        v_upd  = 1'b0;
        z_upd  = 1'b1;
        c_upd  = 1'b0;
        case (op_e)
            OP_ADC, OP_SBC: begin v_upd = 1'b1; c_upd = 1'b1; end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_CMP: c_upd = 1'b1;
            OP_BIT: begin
                n_nxt = opb[W-1];
                v_nxt = opb[W-2];
                z_nxt = ((opa & opb) == '0);
                n_upd = !imm_bit;
                v_upd = !imm_bit;
            end
            OP_TSB, OP_TRB: begin
                z_nxt = ((opa & opb) == '0);
                n_upd = 1'b0;
            end
            default: ;
        endcase
    end

    alu8_flagreg #(.NF(4)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec   (exec),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .upd    ({n_upd, v_upd, z_upd, c_upd}),
        .nxt    ({n_nxt, v_nxt, z_nxt, c_nxt}),
        .status (status)
    );
endmodule

// File: rtl/alu8_status_chk.sv
// Assertion checker for alu8_status, attached by bind below.
// Assumes ld_en and exec stay low while reset is active.
module alu8_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op,
    input logic       imm_bit,
    input logic       exec,
    input logic       ld_en,
    input logic [7:0] ld_val,
    input logic       res_wr,
    input logic       n_nxt,
    input logic       v_nxt,
    input logic       z_nxt,
    input logic       c_nxt,
    input logic       n_upd,
    input logic       v_upd,
    input logic       z_upd,
    input logic       c_upd,
    input logic [7:0] status
);
    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] == 1'b0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> status == ($past(ld_val) & 8'hDF));

    assert_commit_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ld_en && z_upd) |=> status[1] == $past(z_nxt));

    assert_commit_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ld_en && c_upd) |=> status[0] == $past(c_nxt));

    assert_hold_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ld_en && !v_upd) |=> status[6] == $past(status[6]));

    assert_hold_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ld_en && !n_upd) |=> status[7] == $past(status[7]));

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec && !ld_en) |=> $stable(status));

    assert_lsr_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd9) |-> (!n_nxt && n_upd && c_upd));

    assert_cmp_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd6) |-> (!res_wr && !v_upd && c_upd));

    assert_bit_imm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd7 && imm_bit) |-> (!n_upd && !v_upd && z_upd && !c_upd));

    assert_tsb_trb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 4'd14) |-> (z_upd && !n_upd && !v_upd && !c_upd));
endmodule

bind alu8_status alu8_status_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .imm_bit (imm_bit),
    .exec    (exec),
    .ld_en   (ld_en),
    .ld_val  (ld_val),
    .res_wr  (res_wr),
    .n_nxt   (n_nxt),
    .v_nxt   (v_nxt),
    .z_nxt   (z_nxt),
    .c_nxt   (c_nxt),
    .n_upd   (n_upd),
    .v_upd   (v_upd),
    .z_upd   (z_upd),
    .c_upd   (c_upd),
    .status  (status)
);

// File: tb/sim_alu8_status.sv
// Self-checking bench: swept combinational checks of every operation plus
// directed clocked checks of the status byte.
module sim_alu8_status;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] op;
    logic [7:0] opa, opb, ld_val;
    logic       carry_in, dec_in, imm_bit, exec, ld_en;
    logic [7:0] result, status;
    logic       res_wr, n_nxt, v_nxt, z_nxt, c_nxt, n_upd, v_upd, z_upd, c_upd;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    alu8_status u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
        .carry_in(carry_in), .dec_in(dec_in), .imm_bit(imm_bit),
        .exec(exec), .ld_en(ld_en), .ld_val(ld_val),
        .result(result), .res_wr(res_wr),
        .n_nxt(n_nxt), .v_nxt(v_nxt), .z_nxt(z_nxt), .c_nxt(c_nxt),
        .n_upd(n_upd), .v_upd(v_upd), .z_upd(z_upd), .c_upd(c_upd),
        .status(status)
    );

    function automatic int to_dec(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int x);
        return {4'(x / 10), 4'(x % 10)};
    endfunction

    // Reference model: {wr, enN, enV, enZ, enC, n, v, z, c, result[7:0]}
    function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] a,
                                          input logic [7:0] b, input logic c,
                                          input logic d, input logic imm);
        logic [7:0] r, be;
        logic [8:0] t;
        logic n, v, z, co, wr;
        logic [3:0] en;
        int s;
        r = 8'h00; co = 1'b0; v = 1'b0; wr = 1'b1; en = 4'b1010;
        case (o)
            4'd0:  r = b;
            4'd1:  r = a | b;
            4'd2:  r = a & b;
            4'd3:  r = a ^ b;
            4'd4, 4'd5: begin
                be = (o == 4'd5) ? ~b : b;
                t  = 9'(a) + 9'(be) + 9'(c);
                v  = (a[7] == be[7]) && (t[7] != a[7]);
                en = 4'b1111;
                if (!d) begin
                    r = t[7:0]; co = t[8];
                end else if (o == 4'd4) begin
                    s = to_dec(a) + to_dec(b) + int'(c);
                    co = (s >= 100); r = to_bcd(s % 100);
                end else begin
                    s = to_dec(a) - to_dec(b) - 1 + int'(c);
                    co = (s >= 0); if (s < 0) s = s + 100; r = to_bcd(s);
                end
            end
            4'd6:  begin r = a - b; co = (a >= b); wr = 1'b0; en = 4'b1011; end
            4'd7:  begin r = a & b; wr = 1'b0; en = imm ? 4'b0010 : 4'b1110; end
            4'd8:  begin r = b << 1; co = b[7]; en = 4'b1011; end
            4'd9:  begin r = b >> 1; co = b[0]; en = 4'b1011; end
            4'd10: begin r = {b[6:0], c}; co = b[7]; en = 4'b1011; end
            4'd11: begin r = {c, b[7:1]}; co = b[0]; en = 4'b1011; end
            4'd12: r = b + 8'd1;
            4'd13: r = b - 8'd1;
            4'd14: begin r = b | a; en = 4'b0010; end
            default: begin r = b & ~a; en = 4'b0010; end
        endcase
        n = r[7];
        z = (r == 8'h00);
        if (o == 4'd7) begin n = b[7]; v = b[6]; z = ((a & b) == 8'h00); end
        if (o >= 4'd14) z = ((a & b) == 8'h00);
        return {wr, en, n, v, z, co, r};
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic d);
        case (o)
            4'd4, 4'd5: return d ? "R8" : "R7";
            4'd6: return "R9";
            4'd7: return "R10";
            4'd8, 4'd10, 4'd11: return "R5";
            4'd9: return "R6";
            4'd14, 4'd15: return "R11";
            default: return "R4";
        endcase
    endfunction

    // Apply one combinational vector and compare, masking disabled flag values.
    task automatic check_vec(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                             input logic c, input logic d, input logic imm);
        logic [16:0] exp, act;
        logic [3:0]  m;
        op = o; opa = a; opb = b; carry_in = c; dec_in = d; imm_bit = imm;
        #1;
        exp = model(o, a, b, c, d, imm);
        act = {res_wr, n_upd, v_upd, z_upd, c_upd, n_nxt, v_nxt, z_nxt, c_nxt, result};
        m   = exp[15:12];
        total++;
        if (act[16:12] != exp[16:12] || act[7:0] != exp[7:0] ||
            (act[11:8] & m) != (exp[11:8] & m)) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h c=%b d=%b imm=%b actual=%h expected=%h",
                     tag_of(o, d), o, a, b, c, d, imm, act, exp);
        end
    endtask

    task automatic check_status(input logic [7:0] exp, input string tag);
        total++;
        if (status !== exp) begin
            bad++;
            $display("FAIL %s status actual=%h expected=%h", tag, status, exp);
        end
    endtask

    // One clocked step: drive at the falling edge, sample after the rising edge.
    task automatic step(input logic e, input logic l, input logic [7:0] lv,
                        input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic imm);
        @(negedge clk);
        exec = e; ld_en = l; ld_val = lv; op = o; opa = a; opb = b;
        carry_in = c; dec_in = 1'b0; imm_bit = imm;
        @(posedge clk);
        #1;
        exec = 1'b0; ld_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; exec = 1'b0; ld_en = 1'b0; ld_val = 8'h00;
        op = 4'd0; opa = 8'h00; opb = 8'h00; carry_in = 1'b0; dec_in = 1'b0; imm_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_status(8'h04, "R1");

        // Binary sweep of every operation (R4 R5 R6 R7 R9 R10 R11).
        for (int o = 0; o < 16; o++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 17)
                    for (int c = 0; c < 2; c++)
                        for (int im = 0; im < 2; im++)
                            check_vec(4'(o), 8'(a), 8'(b), 1'(c), 1'b0, 1'(im));

        // Decimal sweep over all valid BCD pairs (R8).
        for (int o = 4; o < 6; o++)
            for (int a = 0; a < 100; a++)
                for (int b = 0; b < 100; b++)
                    for (int c = 0; c < 2; c++)
                        check_vec(4'(o), to_bcd(a), to_bcd(b), 1'(c), 1'b1, 1'b0);

        // Status byte directed checks.
        step(1'b0, 1'b1, 8'hFF, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
        check_status(8'hDF, "R2");
        step(1'b1, 1'b0, 8'h00, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
        check_status(8'h5F, "R3");
        step(1'b1, 1'b0, 8'h00, 4'd4, 8'h50, 8'h50, 1'b0, 1'b0);
        check_status(8'hDC, "R7");
        step(1'b1, 1'b1, 8'h00, 4'd0, 8'h00, 8'h80, 1'b0, 1'b0);
        check_status(8'h00, "R2");
        step(1'b1, 1'b0, 8'h00, 4'd7, 8'h00, 8'hC0, 1'b0, 1'b1);
        check_status(8'h02, "R10");
        step(1'b1, 1'b0, 8'h00, 4'd7, 8'h01, 8'hC1, 1'b0, 1'b0);
        check_status(8'hC0, "R10");
        step(1'b0, 1'b0, 8'h00, 4'd4, 8'hFF, 8'hFF, 1'b1, 1'b0);
        check_status(8'hC0, "R3");
        step(1'b1, 1'b0, 8'h00, 4'd9, 8'h00, 8'h01, 1'b0, 1'b0);
        check_status(8'h43, "R6");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule